// File: doc/BRIEF.md
# Host I/O Port Write Snoop FIFO

This block sits beside a host I/O bus decoder and records the bytes that the host writes to one or two chosen I/O port addresses. A typical use is capturing the progress codes that boot firmware emits on a fixed port, so a management processor can follow the boot sequence. The decoder hands over each host cycle already reduced to a single-cycle strobe, a direction bit, a 16-bit address and a data byte. Bus framing and clock domain crossing stay outside the block.

Every byte that matches goes into a 128-entry queue together with a one-bit tag that records which monitor address it came from. The management processor uses a small byte-wide register port for all access. Through it, it sets the two addresses, selects which ones are live, reads a status byte, and pops the queue by reading the data register. A level interrupt stays asserted while entries are waiting and the interrupt is enabled. In double-word mode the first address becomes a four-byte window and the second address is ignored.

Top module: `host_io_snoop`

## Requirements
- R1: After reset all registers read 0x00, the queue is empty and `irq` is low.
- R2: Monitor address A is written as a low byte at offset 0x10 and a high byte at 0x12. Monitor address B uses 0x02 (low) and 0x04 (high). All four bytes read back as written.
- R3: The control register at offset 0x06 holds four bits: bit 7 arms address A, bit 6 arms address B, bit 3 enables the interrupt, and bit 2 selects double-word mode. The other bits always read 0.
- R4: A host write to an armed address pushes the data byte together with a source tag. The tag shows as status bit 0, with 0 for address A and 1 for address B. If both addresses are armed and equal, the capture is tagged as address A and is stored once.
- R5: Host read cycles, writes to addresses that do not match, and writes to an address that is not armed leave the queue unchanged.
- R6: The status register sits at offset 0x08. Bit 7 is 1 while the queue holds data. Reading the data register at offset 0x0A returns the oldest byte and removes it, after which status shows the next entry. Bytes come out in the order they were captured.
- R7: Reading the data register while the queue is empty returns 0x00 and changes nothing.
- R8: The queue holds 128 entries. A capture that arrives while the queue is full is discarded and sets status bit 5. That bit stays set until software writes 1 to bit 5 of the status register. Writing 0 there leaves it set.
- R9: In double-word mode, host writes to address A through address A+3 are each captured and tagged as address A, in the order they are written. Address B is ignored even if it is armed.
- R10: `irq` equals the interrupt enable bit ANDed with "queue not empty". It falls once the last entry is popped.
- R11: Offsets outside the register map, including 0x0C and 0x00, read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostStb | input | 1 | One-cycle strobe marking a decoded host I/O cycle |
| hostIsWrite | input | 1 | 1 when the strobed host cycle is a write |
| hostAddr | input | 16 | Host I/O address of the strobed cycle |
| hostData | input | 8 | Host write data of the strobed cycle |
| regAddr | input | 5 | Register offset on the management port |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdEn | input | 1 | Register read strobe; pops the queue when the data register is addressed |
| regRdData | output | 8 | Contents of the addressed register |
| irq | output | 1 | Level interrupt while data is pending and enabled |

## Verification
The hardest state to reach is the full queue at the moment one more capture arrives. Getting there needs 128 accepted host writes with no pop in between. The bench therefore arms address A alone and issues 129 writes with a counting data pattern. It then checks that the overflow bit set and that a write of 0 does not clear it. Finally it drains all 128 entries and checks that every byte appears in order and that the 129th byte is missing. Double-word mode is reached by arming address B at the same time, so that ignoring B and ignoring address A+4 are both observed through the status register.

// File: rtl/host_io_snoop_pkg.sv
package host_io_snoop_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 2 * DATA_W;
  localparam int unsigned REG_AW  = 5;
  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned DW_SPAN = 4;

  localparam logic [REG_AW-1:0] OFS_B_LO = 5'h02;
  localparam logic [REG_AW-1:0] OFS_B_HI = 5'h04;
  localparam logic [REG_AW-1:0] OFS_CTRL = 5'h06;
  localparam logic [REG_AW-1:0] OFS_STAT = 5'h08;
  localparam logic [REG_AW-1:0] OFS_DATA = 5'h0A;
  localparam logic [REG_AW-1:0] OFS_A_LO = 5'h10;
  localparam logic [REG_AW-1:0] OFS_A_HI = 5'h12;

  localparam int unsigned CTL_ARM_A = 7;
  localparam int unsigned CTL_IRQ   = 3;
  localparam int unsigned CTL_DWORD = 2;
  localparam logic [DATA_W-1:0] CTL_MASK = 8'hCC;

  localparam int unsigned ST_VALID = 7;
  localparam int unsigned ST_OVF   = 5;
  localparam int unsigned ST_TAG   = 0;

  typedef struct packed {
    logic push;
    logic pushTag;
    logic pop;
    logic ovfSet;
    logic ovfClr;
  } snoopStrobe_t;
endpackage

// File: rtl/host_io_snoop_ctrl.sv
module host_io_snoop_ctrl
  import host_io_snoop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostStb,
  input  logic              hostIsWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  input  logic [DATA_W-1:0] headData,
  input  logic              headTag,
  input  logic              ovfFlag,
  output snoopStrobe_t      strb,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq
);
  function automatic logic [REG_AW-1:0] loOfs(input int ch);
    return (ch == 0) ? OFS_A_LO : OFS_B_LO;
  endfunction
  function automatic logic [REG_AW-1:0] hiOfs(input int ch);
    return (ch == 0) ? OFS_A_HI : OFS_B_HI;
  endfunction

  logic [ADDR_W-1:0] monAddr [NUM_CH];
  logic [DATA_W-1:0] ctlReg;
  logic [NUM_CH-1:0] hitExact;
  logic [ADDR_W-1:0] dwOffset;
  logic              hostWrite;
  logic              dwMode;
  logic              dwHit;
  logic              capture;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg <= '0;
      for (int c = 0; c < NUM_CH; c++) monAddr[c] <= '0;
    end else if (regWrEn) begin
      if (regAddr == OFS_CTRL) ctlReg <= regWrData & CTL_MASK;
      for (int c = 0; c < NUM_CH; c++) begin
        if (regAddr == loOfs(c)) monAddr[c][DATA_W-1:0]      <= regWrData;
        if (regAddr == hiOfs(c)) monAddr[c][ADDR_W-1:DATA_W] <= regWrData;
      end
    end
  end

  assign hostWrite = hostStb && hostIsWrite;
  assign dwMode    = ctlReg[CTL_DWORD];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_match
    assign hitExact[g] = hostWrite && ctlReg[CTL_ARM_A-g] && (hostAddr == monAddr[g]);
  end

  assign dwOffset = hostAddr - monAddr[0];
  assign dwHit    = hostWrite && (dwOffset < ADDR_W'(DW_SPAN));
  assign capture  = dwMode ? dwHit : (|hitExact);

  always_comb begin
    strb.pop     = regRdEn && (regAddr == OFS_DATA) && !fifoEmpty;
    strb.pushTag = !dwMode && !hitExact[0] && hitExact[1];
    strb.push    = capture && (!fifoFull || strb.pop);
    strb.ovfSet  = capture && fifoFull && !strb.pop;
    strb.ovfClr  = regWrEn && (regAddr == OFS_STAT) && regWrData[ST_OVF];
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_A_LO: regRdData = monAddr[0][DATA_W-1:0];
      OFS_A_HI: regRdData = monAddr[0][ADDR_W-1:DATA_W];
      OFS_B_LO: regRdData = monAddr[1][DATA_W-1:0];
      OFS_B_HI: regRdData = monAddr[1][ADDR_W-1:DATA_W];
      OFS_CTRL: regRdData = ctlReg;
      OFS_DATA: regRdData = headData;
      OFS_STAT: begin
        regRdData[ST_VALID] = !fifoEmpty;
        regRdData[ST_OVF]   = ovfFlag;
        regRdData[ST_TAG]   = headTag;
      end
      default:  regRdData = '0;
    endcase
  end

  assign irq = ctlReg[CTL_IRQ] && !fifoEmpty;
endmodule

// File: rtl/host_io_snoop_dp.sv
module host_io_snoop_dp
  import host_io_snoop_pkg::*;
#(
  parameter int unsigned DEPTH = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  snoopStrobe_t      strb,
  input  logic [DATA_W-1:0] pushData,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic [DATA_W-1:0] headData,
  output logic              headTag,
  output logic              ovfFlag
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W:0]    mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [CNT_W-1:0]   count;

  assign fifoFull  = (count == CNT_W'(DEPTH));
  assign fifoEmpty = (count == '0);
  assign headData  = fifoEmpty ? '0 : mem[rdPtr][DATA_W-1:0];
  assign headTag   = fifoEmpty ? 1'b0 : mem[rdPtr][DATA_W];

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= {strb.pushTag, pushData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (strb.push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (strb.ovfSet)      ovfFlag <= 1'b1;
      else if (strb.ovfClr) ovfFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/host_io_snoop.sv
module host_io_snoop
  import host_io_snoop_pkg::*;
#(
  parameter int unsigned DEPTH = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostStb,
  input  logic        hostIsWrite,
  input  logic [15:0] hostAddr,
  input  logic [7:0]  hostData,
  input  logic [4:0]  regAddr,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  input  logic        regRdEn,
  output logic [7:0]  regRdData,
  output logic        irq
);
  snoopStrobe_t      strb;
  logic              fifoFull, fifoEmpty, headTag, ovfFlag;
  logic [DATA_W-1:0] headData;

  host_io_snoop_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostStb(hostStb), .hostIsWrite(hostIsWrite),
    .hostAddr(hostAddr), .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .headData(headData), .headTag(headTag), .ovfFlag(ovfFlag),
    .strb(strb), .regRdData(regRdData), .irq(irq)
  );

  host_io_snoop_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pushData(hostData),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .headData(headData),
    .headTag(headTag), .ovfFlag(ovfFlag)
  );
endmodule

// File: rtl/host_io_snoop_chk.sv
module host_io_snoop_chk
  import host_io_snoop_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              hostStb,
  input logic              hostIsWrite,
  input logic [REG_AW-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input snoopStrobe_t      strb,
  input logic              fifoFull,
  input logic              fifoEmpty,
  input logic              ovfFlag,
  input logic              irq
);
  // R8: no entry is accepted into a full queue unless one leaves in the same cycle
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull && !strb.pop |-> !strb.push);

  // R8: the overflow flag holds until an explicit write-one clear
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && !(regWrEn && regAddr == OFS_STAT && regWrData[ST_OVF]) |=> ovfFlag);

  // R8: overflow only appears after the queue was full
  a_r8_ovf_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(fifoFull));

  // R6: a pop is never issued against an empty queue
  a_r6_pop_has_data: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !fifoEmpty);

  // R5: host read cycles never capture
  a_r5_read_ignored: assert property (@(posedge clk) disable iff (!rstN)
    hostStb && !hostIsWrite |-> !strb.push);

  // R10: interrupt only with pending data
  a_r10_irq_pending: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !fifoEmpty);
endmodule

bind host_io_snoop host_io_snoop_chk u_chk (
  .clk(clk), .rstN(rstN), .hostStb(hostStb), .hostIsWrite(hostIsWrite),
  .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .strb(strb),
  .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .ovfFlag(ovfFlag), .irq(irq)
);

// File: tb/host_io_snoop_bench.sv
`timescale 1ns/1ps
module host_io_snoop_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostStb = 1'b0, hostIsWrite = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [7:0]  hostData = '0;
  logic [4:0]  regAddr = '0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  host_io_snoop u_host_io_snoop (
    .clk(clk), .rstN(rstN), .hostStb(hostStb), .hostIsWrite(hostIsWrite),
    .hostAddr(hostAddr), .hostData(hostData), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdData(regRdData), .irq(irq)
  );

  // op: 0 host write, 1 host read, 2 register write, 3 register read and compare
  // fields {op[1:0], addr[15:0], data[7:0], req[3:0]}
  localparam int NVEC = 16;
  localparam logic [29:0] VEC [NVEC] = '{
    {2'd2, 16'h0010, 8'h80, 4'd2},
    {2'd2, 16'h0012, 8'h00, 4'd2},
    {2'd2, 16'h0002, 8'h84, 4'd2},
    {2'd2, 16'h0004, 8'h00, 4'd2},
    {2'd2, 16'h0006, 8'hC8, 4'd3},
    {2'd0, 16'h0080, 8'h11, 4'd4},
    {2'd0, 16'h0084, 8'h22, 4'd4},
    {2'd1, 16'h0080, 8'h99, 4'd5},
    {2'd0, 16'h0081, 8'h33, 4'd5},
    {2'd3, 16'h0008, 8'h80, 4'd6},  // R6 valid, head tag A
    {2'd3, 16'h000A, 8'h11, 4'd4},  // R4 first byte
    {2'd3, 16'h0008, 8'h81, 4'd4},  // R4 head now tagged B
    {2'd3, 16'h000A, 8'h22, 4'd6},  // R6 order kept
    {2'd3, 16'h0008, 8'h00, 4'd5},  // R5 read cycle and miss not stored
    {2'd3, 16'h000A, 8'h00, 4'd7},  // R7 empty read
    {2'd3, 16'h0008, 8'h00, 4'd7}   // R7 no side effect
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, got, exp);
    end
  endtask

  task automatic hostCycle(input logic [15:0] a, input logic [7:0] d, input logic wr);
    @(negedge clk);
    hostStb = 1'b1; hostIsWrite = wr; hostAddr = a; hostData = d;
    @(negedge clk);
    hostStb = 1'b0; hostIsWrite = 1'b0;
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #2 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] v;
    regRead(a, v);
    check(req, v, exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectReg("R1", 5'h08, 8'h00);
    expectReg("R1", 5'h06, 8'h00);
    expectReg("R1", 5'h10, 8'h00);
    expectReg("R1", 5'h0A, 8'h00);
    check("R1", {7'b0, irq}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [29:0] v;
      v = VEC[i];
      case (v[29:28])
        2'd0: hostCycle(v[27:12], v[11:4], 1'b1);
        2'd1: hostCycle(v[27:12], v[11:4], 1'b0);
        2'd2: regWrite(v[16:12], v[11:4]);
        default: expectReg($sformatf("R%0d vector %0d", v[3:0], i), v[16:12], v[11:4]);
      endcase
    end

    // R2 readback of both address bytes
    expectReg("R2", 5'h10, 8'h80);
    expectReg("R2", 5'h02, 8'h84);
    regWrite(5'h12, 8'h5C);
    expectReg("R2", 5'h12, 8'h5C);
    regWrite(5'h12, 8'h00);

    // R3 unused control bits read zero
    regWrite(5'h06, 8'hFF);
    expectReg("R3", 5'h06, 8'hCC);

    // R4 equal addresses both armed: tagged A, stored once
    regWrite(5'h02, 8'h80);
    regWrite(5'h06, 8'hC0);
    hostCycle(16'h0080, 8'h5A, 1'b1);
    expectReg("R4", 5'h08, 8'h80);
    check("R10", {7'b0, irq}, 8'h00);
    expectReg("R4", 5'h0A, 8'h5A);
    expectReg("R4", 5'h08, 8'h00);
    regWrite(5'h02, 8'h84);

    // R5 disarmed address B ignored
    regWrite(5'h06, 8'h80);
    hostCycle(16'h0084, 8'h66, 1'b1);
    expectReg("R5", 5'h08, 8'h00);

    // R8 overflow with interrupt enabled
    regWrite(5'h06, 8'h88);
    hostCycle(16'h0080, 8'h00, 1'b1);
    check("R10", {7'b0, irq}, 8'h01);
    for (int i = 1; i < 129; i++) hostCycle(16'h0080, i[7:0], 1'b1);
    expectReg("R8", 5'h08, 8'hA0);
    regWrite(5'h08, 8'h00);
    expectReg("R8", 5'h08, 8'hA0);
    for (int i = 0; i < 128; i++) expectReg("R8", 5'h0A, i[7:0]);
    expectReg("R8", 5'h08, 8'h20);
    check("R10", {7'b0, irq}, 8'h00);
    regWrite(5'h08, 8'h20);
    expectReg("R8", 5'h08, 8'h00);

    // R9 double-word window, address B armed but ignored
    regWrite(5'h06, 8'h44);
    for (int i = 0; i < 4; i++) hostCycle(16'h0080 + 16'(i), 8'hA0 + 8'(i), 1'b1);
    hostCycle(16'h0084, 8'hB4, 1'b1);
    hostCycle(16'h007F, 8'hB5, 1'b1);
    for (int i = 0; i < 4; i++) begin
      expectReg("R9", 5'h08, 8'h80);
      expectReg("R9", 5'h0A, 8'hA0 + 8'(i));
    end
    expectReg("R9", 5'h08, 8'h00);

    // R11 unmapped offsets
    expectReg("R11", 5'h0C, 8'h00);
    expectReg("R11", 5'h00, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule